// File: doc/BRIEF.md
# Masked Broadcast Node Receiver

This block is the receiving end of one grid node in a SIMD array. A control unit reaches every node over one shared bus. Each node has fixed column and row coordinates. It compares them with the mask plan currently on the bus and forms a match signal. A single membership flag holds the node's selection. The flag is rebuilt by set operations that combine its previous value with the current match: load, intersect, union or symmetric difference. Several broadcasts can follow one mask setup.

A broadcast carries a 32-bit instruction word and a delivery mode. The mode targets member nodes, non-member nodes or all nodes. A node that accepts the word splits it into a 16-bit command, taken from the upper half, and a 16-bit local address, taken from the lower half. It raises a one-cycle valid pulse with them. Both registers keep their value until the next accepted broadcast.

Top module: `mbn_node`

## Requirements
- R1: `hit` is 1 exactly when `col_map[COL_IDX]` and `row_map[ROW_IDX]` are both 1, combinationally.
- R2: The flag resets to 0. After reset, `sel_flag` is 0, `rx_valid` is 0, and `rx_cmd` and `rx_addr` are 0.
- R3: A mask strobe with op code 2'b00 (load) sets the flag to `hit`, visible in the next cycle.
- R4: Op code 2'b01 (intersect) sets the flag to flag AND `hit`.
- R5: Op code 2'b10 (union) sets the flag to flag OR `hit`.
- R6: Op code 2'b11 (toggle) sets the flag to flag XOR `hit`.
- R7: A broadcast strobe in mode 2'b01 (members) delivers only when the flag is 1. Mode 2'b10 (non-members) delivers only when the flag is 0. Mode 2'b00 (all) always delivers. Mode 2'b11 never delivers.
- R8: On delivery, `rx_cmd` takes `bc_word[31:16]` and `rx_addr` takes `bc_word[15:0]` in the next cycle. `rx_valid` is high for exactly that one cycle.
- R9: Without a delivery, `rx_cmd` and `rx_addr` hold their value and `rx_valid` is 0.
- R10: A broadcast does not change the flag.
- R11: When a mask strobe and a broadcast strobe arrive in the same cycle, the mask operation is applied and the broadcast is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_stb | input | 1 | Mask operation strobe |
| mask_op | input | 2 | Set operation code |
| col_map | input | 16 | Column bitmap of the mask plan |
| row_map | input | 16 | Row bitmap of the mask plan |
| bc_stb | input | 1 | Broadcast strobe |
| bc_mode | input | 2 | Delivery mode |
| bc_word | input | 32 | Broadcast instruction word |
| hit | output | 1 | Node matches the current mask plan |
| sel_flag | output | 1 | Membership flag |
| rx_valid | output | 1 | One-cycle pulse on delivery |
| rx_cmd | output | 16 | Captured command half |
| rx_addr | output | 16 | Captured local-address half |

## Verification
A mask update and a broadcast can fall in the same cycle. The bench provokes this collision in a directed case and also lets random stimulus raise both strobes together. Each collision is judged on two points: the flag must follow the set operation, and there must be no valid pulse. The capture registers must also keep their earlier contents, which shows that the dropped broadcast was evaluated against neither the old flag nor the new one.

// File: rtl/mbn_pkg.sv
package mbn_pkg;
  typedef enum logic [1:0] {
    MOP_LOAD = 2'b00,
    MOP_AND  = 2'b01,
    MOP_OR   = 2'b10,
    MOP_XOR  = 2'b11
  } mask_op_e;

  typedef enum logic [1:0] {
    BM_ALL  = 2'b00,
    BM_SEL  = 2'b01,
    BM_INV  = 2'b10,
    BM_NONE = 2'b11
  } bc_mode_e;

  function automatic logic flag_next(input logic [1:0] op, input logic cur, input logic h);
    case (op)
      MOP_LOAD: flag_next = h;
      MOP_AND:  flag_next = cur & h;
      MOP_OR:   flag_next = cur | h;
      default:  flag_next = cur ^ h;
    endcase
  endfunction

  function automatic logic accepts(input logic [1:0] mode, input logic f);
    case (mode)
      BM_ALL:  accepts = 1'b1;
      BM_SEL:  accepts = f;
      BM_INV:  accepts = ~f;
      default: accepts = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mbn_match.sv
module mbn_match #(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int COL_IDX = 0,
  parameter int ROW_IDX = 0
) (
  input  logic [COLS-1:0] col_map,
  input  logic [ROWS-1:0] row_map,
  output logic            hit
);
  assign hit = col_map[COL_IDX] & row_map[ROW_IDX];
endmodule

// File: rtl/mbn_flag.sv
module mbn_flag
  import mbn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_stb,
  input  logic [1:0] mask_op,
  input  logic       hit,
  output logic       flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (mask_stb) flag <= flag_next(mask_op, flag, hit);
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_stb |=> $stable(flag)); // R10
  AST_LOAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stb && mask_op == 2'b00) |=> (flag == $past(hit))); // R3
endmodule

// File: rtl/mbn_capture.sv
module mbn_capture
  import mbn_pkg::*;
#(
  parameter int WW = 32,
  localparam int HW = WW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deliver,
  input  logic [WW-1:0] word,
  output logic          valid,
  output logic [HW-1:0] cmd,
  output logic [HW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cmd   <= '0;
      addr  <= '0;
    end else begin
      valid <= deliver;
      if (deliver) begin
        cmd  <= word[WW-1:HW];
        addr <= word[HW-1:0];
      end
    end
  end

  AST_HOLD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |=> ($stable(cmd) && $stable(addr) && !valid)); // R9
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> (valid && cmd == $past(word[WW-1:HW]) && addr == $past(word[HW-1:0]))); // R8
endmodule

// File: rtl/mbn_node.sv
module mbn_node
  import mbn_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int COL_IDX = 5,
  parameter int ROW_IDX = 10,
  parameter int WW = 32,
  localparam int HW = WW / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_stb,
  input  logic [1:0]      mask_op,
  input  logic [COLS-1:0] col_map,
  input  logic [ROWS-1:0] row_map,
  input  logic            bc_stb,
  input  logic [1:0]      bc_mode,
  input  logic [WW-1:0]   bc_word,
  output logic            hit,
  output logic            sel_flag,
  output logic            rx_valid,
  output logic [HW-1:0]   rx_cmd,
  output logic [HW-1:0]   rx_addr
);
  logic deliver;
  logic collide;

  mbn_match #(.COLS(COLS), .ROWS(ROWS), .COL_IDX(COL_IDX), .ROW_IDX(ROW_IDX)) u_match (
    .col_map(col_map), .row_map(row_map), .hit(hit));

  mbn_flag u_flag (
    .clk(clk), .rst_n(rst_n), .mask_stb(mask_stb), .mask_op(mask_op),
    .hit(hit), .flag(sel_flag));

  assign collide = mask_stb & bc_stb;
  assign deliver = bc_stb & ~mask_stb & accepts(bc_mode, sel_flag);

  mbn_capture #(.WW(WW)) u_cap (
    .clk(clk), .rst_n(rst_n), .deliver(deliver), .word(bc_word),
    .valid(rx_valid), .cmd(rx_cmd), .addr(rx_addr));

  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> !rx_valid); // R11
  AST_INV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_stb && bc_mode == 2'b10 && sel_flag) |=> !rx_valid); // R7
  AST_SEL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_stb && bc_mode == 2'b01 && !sel_flag) |=> !rx_valid); // R7
  AST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (col_map[COL_IDX] && row_map[ROW_IDX])); // R1
endmodule

// File: tb/mbn_node_bench.sv
module mbn_node_bench;
  localparam int CX = 5;
  localparam int RY = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic mask_stb = 0;
  logic [1:0] mask_op = 0;
  logic [15:0] col_map = 0, row_map = 0;
  logic bc_stb = 0;
  logic [1:0] bc_mode = 0;
  logic [31:0] bc_word = 0;
  logic hit, sel_flag, rx_valid;
  logic [15:0] rx_cmd, rx_addr;

  int tests = 0, fails = 0;
  logic m_flag;
  logic [15:0] m_cmd, m_addr;

  always #4 clk = ~clk;

  mbn_node #(.COL_IDX(CX), .ROW_IDX(RY)) u_mbn_node (
    .clk(clk), .rst_n(rst_n), .mask_stb(mask_stb), .mask_op(mask_op),
    .col_map(col_map), .row_map(row_map), .bc_stb(bc_stb), .bc_mode(bc_mode),
    .bc_word(bc_word), .hit(hit), .sel_flag(sel_flag), .rx_valid(rx_valid),
    .rx_cmd(rx_cmd), .rx_addr(rx_addr));

  function automatic logic exp_hit(input logic [15:0] c, input logic [15:0] r);
    return c[CX] && r[RY];
  endfunction

  function automatic logic exp_flag(input logic [1:0] op, input logic f, input logic h);
    if (op == 2'b00) return h;
    if (op == 2'b01) return f && h;
    if (op == 2'b10) return f || h;
    return f != h;
  endfunction

  function automatic logic exp_take(input logic [1:0] md, input logic f);
    return (md == 2'b00) || (md == 2'b01 && f) || (md == 2'b10 && !f);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, clock edge, check after next negedge
  task automatic step(input logic ms, input logic [1:0] op, input logic [15:0] c,
                      input logic [15:0] r, input logic bs, input logic [1:0] md,
                      input logic [31:0] w, input string tag);
    logic h, take;
    mask_stb = ms; mask_op = op; col_map = c; row_map = r;
    bc_stb = bs; bc_mode = md; bc_word = w;
    #1;
    h = exp_hit(c, r);
    chk("R1", {31'b0, hit}, {31'b0, h});
    take = bs && !ms && exp_take(md, m_flag);
    if (ms) m_flag = exp_flag(op, m_flag, h);
    if (take) begin m_cmd = w[31:16]; m_addr = w[15:0]; end
    @(negedge clk);
    mask_stb = 0; bc_stb = 0;
    chk(tag, {31'b0, sel_flag}, {31'b0, m_flag});
    chk(tag, {31'b0, rx_valid}, {31'b0, take});
    chk(tag, {rx_cmd, rx_addr}, {m_cmd, m_addr});
  endtask

  initial begin
    #1500000;
    fails++; tests++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [15:0] on;
    seed = 7;
    void'($urandom(seed));
    on = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_flag = 0; m_cmd = 0; m_addr = 0;
    chk("R2", {29'b0, sel_flag, rx_valid, 1'b0}, 32'h0);
    chk("R2", {rx_cmd, rx_addr}, 32'h0);
    // directed: R3 load hit, R7 members
    step(1, 2'b00, 16'h1 << CX, 16'h1 << RY, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 2'b01, 32'hD5F5021A, "R7_sel");
    step(0, 0, 0, 0, 1, 2'b10, 32'h11112222, "R7_inv_block");
    step(0, 0, 0, 0, 1, 2'b01, 32'hABCD1234, "R10_R8");
    step(0, 0, 0, 0, 0, 0, 32'hFFFFFFFF, "R9");
    step(1, 2'b01, 16'hFFFF, ~(16'h1 << RY), 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 2'b10, 32'h55667788, "R7_inv");
    step(0, 0, 0, 0, 1, 2'b11, 32'h99999999, "R7_none");
    step(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R5");
    step(1, 2'b11, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 2'b00, 32'h0BAD0F00, "R7_all");
    // R11 collision
    step(1, 2'b10, 16'hFFFF, 16'hFFFF, 1, 2'b00, 32'hDEADBEEF, "R11");
    step(1, 2'b00, 16'h0, 16'h0, 1, 2'b10, 32'hCAFEF00D, "R11");
    // random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] c, r;
      c = $urandom; r = $urandom;
      if ($urandom % 2) c[CX] = 1;
      if ($urandom % 2) r[RY] = 1;
      step($urandom % 3 == 0, 2'($urandom), c, r, $urandom % 2 == 0,
           2'($urandom), $urandom, "R3_R4_R5_R6_R7_R11_rand");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule